// File: doc/BRIEF.md
# Interleaved Multi-Bank Array Memory

This block holds a logical array of `DEPTH` words split over several small physical banks. The split lets several elements be read in the same cycle. A compile-time parameter picks one of three mappings. Cyclic interleaving deals neighbouring indices to neighbouring banks. Block split gives each bank one contiguous run of indices. Complete split turns every element into its own register. A second parameter sets the number of banks in the first two mappings.

A client presents `RD_PORTS` logical indices at once on one read strobe. It can also present one logical write per cycle. The block turns each index into a bank number and a local offset. Each bank serves at most two reads per cycle. When a request puts more reads on one bank, the block serves the lower-numbered ports first and raises `busy` for the extra cycles. It then delivers all words together with `rd_vld`.

The array starts from a fixed preload at power-on. The run-time reset clears only the control state, so the array contents survive it.

Top module: `banked_array_mem`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy` and `rd_vld` are 0.
- R2: A request is accepted when `rd_req` is high and `busy` is low. If no bank receives more than two of its in-range indices, `rd_vld` is high at the next clock edge, and `rd_data` then holds word p of the array in bits [p*WIDTH +: WIDTH] for port p. `busy` stays low.
- R3: In cyclic mode (`MODE`=0), index i lives in bank i mod `BANKS` at offset i / `BANKS`.
- R4: In block mode (`MODE`=1), index i lives in bank i / ceil(`DEPTH`/`BANKS`). When `DEPTH` is not a multiple, the last bank is shorter.
- R5: In complete mode (`MODE`=2), every element is its own register. Any set of `RD_PORTS` indices is returned in one cycle, and `busy` never rises.
- R6: A bank serves at most two reads per cycle, and lower-numbered ports go first. Let L be the largest number of in-range indices that fall in one bank. `rd_vld` rises ceil(L/2) edges after acceptance (at least 1), and `busy` is high in the cycles between.
- R7: `rd_req` is ignored while `busy` is high. The pending request completes with its own indices, and no extra `rd_vld` follows.
- R8: When `wr_en` is high, `wr_data` is stored at `wr_idx` at the clock edge, and later reads return it.
- R9: A read served in the same cycle as a write to the same index returns the value held before that write.
- R10: At power-on, element i holds (5*i + 3) mod 2^`WIDTH`. A later assertion of `rst_n` leaves the array contents unchanged.
- R11: An index of `DEPTH` or more reads as 0 and uses no bank port. A write to such an index changes no element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| rd_req | input | 1 | Read request strobe for all ports |
| rd_idx | input | RD_PORTS*IW | Logical index per port, port p in bits [p*IW +: IW] |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IW | Logical write index |
| wr_data | input | WIDTH | Write word |
| busy | output | 1 | Bank conflict stall in progress; requests ignored |
| rd_vld | output | 1 | All read words of the last request are on `rd_data` |
| rd_data | output | RD_PORTS*WIDTH | Read word per port |

## Verification
A wrong bank or offset decode returns another element's word in the very cycle `rd_vld` rises. The preload pattern is distinct for each index, so the word shows which element was read. A wrong conflict count shifts `rd_vld` by one or more cycles, or raises `busy` where it must stay low. The bench compares arrival cycles against its own per-mode load count. A lost write, or contents cleared by reset, appears on the first later read of that index.

// File: rtl/bam_pkg.sv
package bam_pkg;

    typedef enum logic [1:0] {
        MAP_CYCLIC   = 2'd0,
        MAP_BLOCK    = 2'd1,
        MAP_COMPLETE = 2'd2
    } map_e;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int bank_of(input int idx, input int depth, input int banks, input map_e m);
        case (m)
            MAP_CYCLIC: return idx % banks;
            MAP_BLOCK:  return idx / ceil_div(depth, banks);
            default:    return idx;
        endcase
    endfunction

    function automatic int offset_of(input int idx, input int depth, input int banks, input map_e m);
        case (m)
            MAP_CYCLIC: return idx / banks;
            MAP_BLOCK:  return idx % ceil_div(depth, banks);
            default:    return 0;
        endcase
    endfunction

    function automatic int index_of(input int b, input int off, input int depth, input int banks, input map_e m);
        case (m)
            MAP_CYCLIC: return off * banks + b;
            MAP_BLOCK:  return b * ceil_div(depth, banks) + off;
            default:    return b;
        endcase
    endfunction

    // number of elements a bank holds; the last bank may be short
    function automatic int bank_len(input int b, input int depth, input int banks, input map_e m);
        int c;
        int rem;
        case (m)
            MAP_CYCLIC: return (b < depth) ? ((depth - 1 - b) / banks + 1) : 0;
            MAP_BLOCK: begin
                c   = ceil_div(depth, banks);
                rem = depth - b * c;
                return (rem <= 0) ? 0 : ((rem < c) ? rem : c);
            end
            default: return 1;
        endcase
    endfunction

    function automatic int preload_word(input int idx);
        return idx * 5 + 3;
    endfunction

endpackage

// File: rtl/bam_bank.sv
module bam_bank
    import bam_pkg::*;
#(
    parameter int   WIDTH   = 16,
    parameter int   LEN     = 4,
    parameter int   SLOTS   = 2,
    parameter int   OW      = 2,
    parameter int   BANK_ID = 0,
    parameter int   DEPTH   = 10,
    parameter int   BANKS   = 3,
    parameter map_e MODE    = MAP_CYCLIC
) (
    input  logic                   clk,
    input  logic [SLOTS*OW-1:0]    rd_off,
    output logic [SLOTS*WIDTH-1:0] rd_word,
    input  logic                   wr_en,
    input  logic [OW-1:0]          wr_off,
    input  logic [WIDTH-1:0]       wr_data
);

    localparam int SZ = (LEN < 1) ? 1 : LEN;
    localparam int LW = (SZ > 1) ? $clog2(SZ) : 1;

    logic [WIDTH-1:0] mem_q [SZ];

    // power-on contents; no run-time reset of the storage
    initial begin
        for (int o = 0; o < LEN; o++) begin
            mem_q[o] = WIDTH'(preload_word(index_of(BANK_ID, o, DEPTH, BANKS, MODE)));
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_off[LW-1:0]] <= wr_data;
        end
    end

    // read slots see the contents before any write of this cycle
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            if (int'(rd_off[s*OW +: OW]) < LEN) begin
                rd_word[s*WIDTH +: WIDTH] = mem_q[rd_off[s*OW +: LW]];
            end else begin
                rd_word[s*WIDTH +: WIDTH] = '0;
            end
        end
    end

endmodule

// File: rtl/bam_sched.sv
module bam_sched #(
    parameter int P     = 4,
    parameter int NB    = 3,
    parameter int SLOTS = 2,
    parameter int BW    = 2,
    parameter int SW    = 1
) (
    input  logic [P-1:0]    pend,
    input  logic [P-1:0]    in_rng,
    input  logic [P*BW-1:0] bank_sel,
    output logic [P-1:0]    grant,
    output logic [P*SW-1:0] slot_of
);

    int used [NB];

    // lowest port first; each bank hands out SLOTS read slots per cycle
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            used[b] = 0;
        end
        grant   = '0;
        slot_of = '0;
        for (int p = 0; p < P; p++) begin
            if (pend[p]) begin
                if (!in_rng[p]) begin
                    grant[p] = 1'b1;
                end else if (used[int'(bank_sel[p*BW +: BW])] < SLOTS) begin
                    grant[p]            = 1'b1;
                    slot_of[p*SW +: SW] = SW'(used[int'(bank_sel[p*BW +: BW])]);
                    used[int'(bank_sel[p*BW +: BW])] = used[int'(bank_sel[p*BW +: BW])] + 1;
                end
            end
        end
    end

endmodule

// File: rtl/banked_array_mem.sv
module banked_array_mem
    import bam_pkg::*;
#(
    parameter int   DEPTH    = 10,
    parameter int   WIDTH    = 16,
    parameter int   BANKS    = 3,
    parameter int   RD_PORTS = 4,
    parameter map_e MODE     = MAP_CYCLIC,
    localparam int  IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_req,
    input  logic [RD_PORTS*IW-1:0]    rd_idx,
    input  logic                      wr_en,
    input  logic [IW-1:0]             wr_idx,
    input  logic [WIDTH-1:0]          wr_data,
    output logic                      busy,
    output logic                      rd_vld,
    output logic [RD_PORTS*WIDTH-1:0] rd_data
);

    localparam int P      = RD_PORTS;
    localparam int NB     = (MODE == MAP_COMPLETE) ? DEPTH : BANKS;
    localparam int SLOTS  = (MODE == MAP_COMPLETE) ? RD_PORTS : 2;
    localparam int MAXLEN = (MODE == MAP_COMPLETE) ? 1 : ceil_div(DEPTH, BANKS);
    localparam int OW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
    localparam int BW     = (NB > 1) ? $clog2(NB) : 1;
    localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic               busy;
        logic               vld;
        logic [P-1:0]       pend;
        logic [P*IW-1:0]    idx;
        logic [P*WIDTH-1:0] data;
    } state_t;

    state_t state_d, state_q;

    logic [P*IW-1:0]          cur_idx;
    logic [P-1:0]             cur_pend;
    logic [P-1:0]             in_rng;
    logic [P*BW-1:0]          port_bank;
    logic [P*OW-1:0]          port_off;
    logic [P-1:0]             grant;
    logic [P*SW-1:0]          slot_of;
    logic [SLOTS*OW-1:0]      bank_off [NB];
    logic [SLOTS*WIDTH-1:0]   bank_word [NB];
    logic                     wr_rng;
    logic [BW-1:0]            wr_bank;
    logic [OW-1:0]            wr_off;

    // index translation for the ports in service this cycle
    always_comb begin
        cur_idx  = state_q.busy ? state_q.idx : rd_idx;
        cur_pend = state_q.busy ? state_q.pend : (rd_req ? {P{1'b1}} : '0);
        for (int p = 0; p < P; p++) begin
            in_rng[p]             = int'(cur_idx[p*IW +: IW]) < DEPTH;
            port_bank[p*BW +: BW] = in_rng[p] ?
                BW'(bank_of(int'(cur_idx[p*IW +: IW]), DEPTH, BANKS, MODE)) : '0;
            port_off[p*OW +: OW]  = in_rng[p] ?
                OW'(offset_of(int'(cur_idx[p*IW +: IW]), DEPTH, BANKS, MODE)) : '0;
        end
        wr_rng  = int'(wr_idx) < DEPTH;
        wr_bank = wr_rng ? BW'(bank_of(int'(wr_idx), DEPTH, BANKS, MODE)) : '0;
        wr_off  = wr_rng ? OW'(offset_of(int'(wr_idx), DEPTH, BANKS, MODE)) : '0;
    end

    bam_sched #(
        .P    (P),
        .NB   (NB),
        .SLOTS(SLOTS),
        .BW   (BW),
        .SW   (SW)
    ) u_sched (
        .pend    (cur_pend),
        .in_rng  (in_rng),
        .bank_sel(port_bank),
        .grant   (grant),
        .slot_of (slot_of)
    );

    // route each granted port's offset to its bank slot
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_off[b] = '0;
        end
        for (int p = 0; p < P; p++) begin
            if (grant[p] && in_rng[p]) begin
                bank_off[int'(port_bank[p*BW +: BW])][int'(slot_of[p*SW +: SW])*OW +: OW] =
                    port_off[p*OW +: OW];
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bam_bank #(
            .WIDTH  (WIDTH),
            .LEN    (bank_len(b, DEPTH, BANKS, MODE)),
            .SLOTS  (SLOTS),
            .OW     (OW),
            .BANK_ID(b),
            .DEPTH  (DEPTH),
            .BANKS  (BANKS),
            .MODE   (MODE)
        ) u_bank (
            .clk    (clk),
            .rd_off (bank_off[b]),
            .rd_word(bank_word[b]),
            .wr_en  (wr_en && wr_rng && (int'(wr_bank) == b)),
            .wr_off (wr_off),
            .wr_data(wr_data)
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.idx  = cur_idx;
        state_d.pend = cur_pend & ~grant;
        state_d.busy = |(cur_pend & ~grant);
        state_d.vld  = (|cur_pend) && !(|(cur_pend & ~grant));
        for (int p = 0; p < P; p++) begin
            if (grant[p]) begin
                state_d.data[p*WIDTH +: WIDTH] = in_rng[p] ?
                    bank_word[int'(port_bank[p*BW +: BW])][int'(slot_of[p*SW +: SW])*WIDTH +: WIDTH] :
                    '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy    = state_q.busy;
    assign rd_vld  = state_q.vld;
    assign rd_data = state_q.data;

endmodule

// File: rtl/bam_chk.sv
module bam_chk
    import bam_pkg::*;
#(
    parameter map_e MODE = MAP_CYCLIC,
    parameter int   P    = 4
) (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic busy,
    input logic rd_vld
);

    localparam int MAX_BUSY = (P + 1) / 2 - 1;

    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else begin
            run_q <= busy ? run_q + 1 : 0;
        end
    end

    AST_ACCEPT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !busy) |=> (rd_vld || busy)); // R2

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !busy) |=> !rd_vld); // R7

    AST_STALL_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || rd_vld)); // R6

    AST_VLD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> !busy); // R6

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < MAX_BUSY)); // R6

    AST_COMPLETE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MAP_COMPLETE) |-> !busy); // R5

endmodule

bind banked_array_mem bam_chk #(
    .MODE(MODE),
    .P   (RD_PORTS)
) u_bam_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_req(rd_req),
    .busy  (busy),
    .rd_vld(rd_vld)
);

// File: tb/test_banked_array_mem.sv
module test_banked_array_mem;
    import bam_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 10;
    localparam int W  = 16;
    localparam int B  = 3;
    localparam int P  = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [2:0]     rq;
    logic [P*IW-1:0] ridx;
    logic           we;
    logic [IW-1:0]  widx;
    logic [W-1:0]   wdat;
    logic           bsy [3];
    logic           vld [3];
    logic [P*W-1:0] rdat [3];

    banked_array_mem #(.DEPTH(N), .WIDTH(W), .BANKS(B), .RD_PORTS(P), .MODE(MAP_CYCLIC)) i_banked_array_mem (
        .clk(clk), .rst_n(rst_n), .rd_req(rq[0]), .rd_idx(ridx), .wr_en(we), .wr_idx(widx),
        .wr_data(wdat), .busy(bsy[0]), .rd_vld(vld[0]), .rd_data(rdat[0]));
    banked_array_mem #(.DEPTH(N), .WIDTH(W), .BANKS(B), .RD_PORTS(P), .MODE(MAP_BLOCK)) i_banked_array_mem_blk (
        .clk(clk), .rst_n(rst_n), .rd_req(rq[1]), .rd_idx(ridx), .wr_en(we), .wr_idx(widx),
        .wr_data(wdat), .busy(bsy[1]), .rd_vld(vld[1]), .rd_data(rdat[1]));
    banked_array_mem #(.DEPTH(N), .WIDTH(W), .BANKS(B), .RD_PORTS(P), .MODE(MAP_COMPLETE)) i_banked_array_mem_cmp (
        .clk(clk), .rst_n(rst_n), .rd_req(rq[2]), .rd_idx(ridx), .wr_en(we), .wr_idx(widx),
        .wr_data(wdat), .busy(bsy[2]), .rd_vld(vld[2]), .rd_data(rdat[2]));

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model [N];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [P*IW-1:0] pk(input int a, input int b, input int c, input int d);
        return {IW'(d), IW'(c), IW'(b), IW'(a)};
    endfunction

    // cycles to finish: per-mode bank load, two reads per bank per cycle
    function automatic int exp_lat(input int m, input logic [P*IW-1:0] ix);
        int cnt [N];
        int mx;
        int i;
        int bk;
        for (int b = 0; b < N; b++) cnt[b] = 0;
        mx = 0;
        for (int p = 0; p < P; p++) begin
            i = int'(ix[p*IW +: IW]);
            if (i < N) begin
                bk = (m == 0) ? (i % B) : ((m == 1) ? (i / ((N + B - 1) / B)) : i);
                cnt[bk]++;
                if (cnt[bk] > mx) mx = cnt[bk];
            end
        end
        if (m == 2) return 1;
        return (mx <= 2) ? 1 : (mx + 1) / 2;
    endfunction

    task automatic do_write(input int i, input logic [W-1:0] d);
        @(negedge clk);
        we = 1'b1; widx = IW'(i); wdat = d;
        @(negedge clk);
        we = 1'b0;
        if (i < N) model[i] = d;
    endtask

    task automatic do_read(input logic [P*IW-1:0] ix, input bit jam, input bit wr,
                           input int wi, input logic [W-1:0] wd, input string tag);
        logic [P*W-1:0] expd;
        int lat [3];
        bit seen [3];
        for (int p = 0; p < P; p++) begin
            expd[p*W +: W] = (int'(ix[p*IW +: IW]) < N) ? model[int'(ix[p*IW +: IW])] : '0;
        end
        for (int j = 0; j < 3; j++) begin
            lat[j]  = exp_lat(j, ix);
            seen[j] = 1'b0;
        end
        @(negedge clk);
        rq = 3'b111; ridx = ix;
        if (wr) begin we = 1'b1; widx = IW'(wi); wdat = wd; end
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 1) begin
                rq = jam ? 3'b001 : 3'b000;
                if (jam) ridx = pk(1, 1, 1, 1);
                if (wr) begin we = 1'b0; if (wi < N) model[wi] = wd; end
            end
            if (k == 2) rq = 3'b000;
            for (int j = 0; j < 3; j++) begin
                if (k == 1) chk(bsy[j] == (lat[j] > 1), (j == 2) ? "R5" : "R6", "busy after accept",
                                longint'(bsy[j]), longint'(lat[j] > 1));
                if (vld[j]) begin
                    if (!seen[j]) begin
                        seen[j] = 1'b1;
                        chk(k == lat[j], (j == 2) ? "R5" : "R6", "rd_vld cycle", k, lat[j]);
                        chk(rdat[j] == expd, tag, $sformatf("rd_data mode %0d", j), rdat[j], expd);
                    end else begin
                        chk(1'b0, "R7", $sformatf("extra rd_vld mode %0d", j), k, 0);
                    end
                end
            end
        end
        for (int j = 0; j < 3; j++) begin
            if (!seen[j]) chk(1'b0, tag, $sformatf("no rd_vld mode %0d", j), 0, lat[j]);
        end
    endtask

    task automatic chk_idle(input string why);
        for (int j = 0; j < 3; j++) begin
            chk(!bsy[j] && !vld[j], "R1", why, {bsy[j], vld[j]}, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        rq = '0; ridx = '0; we = 1'b0; widx = '0; wdat = '0;
        for (int i = 0; i < N; i++) model[i] = W'(i * 5 + 3);
        repeat (3) @(negedge clk);
        chk_idle("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("after reset");

        // directed mapping and conflict cases
        do_read(pk(0, 1, 2, 3), 1'b0, 1'b0, 0, '0, "R10");
        do_read(pk(0, 3, 6, 9), 1'b0, 1'b0, 0, '0, "R3");
        do_read(pk(8, 9, 8, 9), 1'b0, 1'b0, 0, '0, "R4");
        do_read(pk(9, 8, 7, 6), 1'b0, 1'b0, 0, '0, "R5");
        do_read(pk(3, 3, 3, 3), 1'b0, 1'b0, 0, '0, "R6");
        do_read(pk(10, 11, 15, 2), 1'b0, 1'b0, 0, '0, "R11");

        do_write(5, 16'hBEEF);
        do_write(12, 16'h1234);
        do_read(pk(5, 4, 6, 7), 1'b0, 1'b0, 0, '0, "R8");
        do_read(pk(0, 1, 2, 3), 1'b0, 1'b0, 0, '0, "R11");
        do_read(pk(8, 9, 12, 13), 1'b0, 1'b0, 0, '0, "R11");

        // read and write of index 4 in the same cycle: old value first
        do_read(pk(4, 0, 2, 3), 1'b0, 1'b1, 4, 16'hCAFE, "R9");
        do_read(pk(4, 1, 2, 3), 1'b0, 1'b0, 0, '0, "R8");

        // new request while the cyclic instance stalls
        do_read(pk(0, 3, 6, 9), 1'b1, 1'b0, 0, '0, "R7");

        for (int n = 0; n < 80; n++) begin
            if ($urandom_range(0, 9) < 3) begin
                do_write(int'($urandom_range(0, 11)), W'($urandom));
            end else begin
                do_read(pk(int'($urandom_range(0, 11)), int'($urandom_range(0, 11)),
                           int'($urandom_range(0, 11)), int'($urandom_range(0, 11))),
                        1'b0, 1'b0, 0, '0, "R2");
            end
        end

        // run-time reset keeps the contents
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("after mid-run reset");
        do_read(pk(0, 1, 2, 3), 1'b0, 1'b0, 0, '0, "R10");
        do_read(pk(4, 5, 6, 7), 1'b0, 1'b0, 0, '0, "R10");
        do_read(pk(8, 9, 0, 1), 1'b0, 1'b0, 0, '0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule